// File: doc/BRIEF.md
# Split-Latch Multi-Level Cell Page Buffer Controller

This block fronts one bank of two-bit-per-cell memory in which the low bit and the high bit of every cell belong to two different logical pages. Each row of the bank therefore carries a low page and a high page. The per-cell sense latches are split into two page buffers. The low buffer and the high buffer each remember their own open row and their own dirty state, so they can hold pages from unrelated rows at once.

Requests arrive on a valid/ready port as a block address, a write flag and one 64-byte block. A hit in the addressed buffer is served in the cycle it is accepted. A read returns its data one cycle later with a one-cycle valid pulse. On a miss, a dirty victim is programmed back into the cell array first. The requested page is then loaded from the array and the request is retried. If the other buffer is also dirty and holds the same row, both pages are written in one combined program. That program takes the long latency only when at least one high bit actually changes. The cell array is modelled as plain storage with a latency counter.

Top module: `mlc_pagebuf`

## Requirements
- R1: Address map with `BPP` blocks per page and interleave `X`. The low `log2(2*BPP)` address bits are the block `b` within the row, and the bits above them are the row. With group `g = b / X`, the page is the low bit of `g` (0 = low page, 1 = high page), and the slot is `(g / 2) * X + (b mod X)`.
- R2: The low and high buffers hit independently. A request is accepted without any array operation when the buffer of its page is valid and holds its row, whatever the other buffer holds.
- R3: A write hit stores the block in the buffer and marks that buffer dirty. A read hit raises `rsp_valid` for exactly one cycle, one cycle after acceptance, with the latest data of that block.
- R4: A miss on a clean or empty buffer starts no program. The controller loads the page from the array, stays busy for `T_LOAD` cycles, and then accepts the request.
- R5: A miss on a dirty buffer first pulses `prog_start` and writes that page back to its own row. The load follows, and the written data is returned when the row is read again later.
- R6: When the victim is dirty and the other buffer is dirty and open on the same row, one program writes both pages. This program raises `prog_dual`, and both buffers become clean.
- R7: A program that changes the high bit of any cell in the row raises `prog_slow` and holds the array for `T_FULL` cycles. Every other program holds it for `T_LSB` cycles.
- R8: While a program or load is in progress, `busy` is high and `req_ready` stays low.
- R9: `hit_lsb`/`hit_msb` count requests that are accepted without a load. `miss_lsb`/`miss_msb` count loads, each per page.
- R10: After reset, both buffers are empty, the array reads as zero, all counters are zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Block address (row, block in row) |
| req_wdata | input | DW | Write block |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DW | Read data |
| busy | output | 1 | Array operation in progress |
| prog_start | output | 1 | Pulse: a program began |
| prog_dual | output | 1 | Pulse: that program wrote both pages |
| prog_slow | output | 1 | Pulse: that program uses the long latency |
| hit_lsb | output | CW | Low-page hit count |
| hit_msb | output | CW | High-page hit count |
| miss_lsb | output | CW | Low-page load count |
| miss_msb | output | CW | High-page load count |

## Verification
The assertions check four things on every cycle. No request is accepted while busy. Read pulses follow only accepted reads. Hit counters move only on acceptance. Each program's start pulse coincides with a counter loaded to the latency its slow flag announces. Only the bench's scenarios can show the rest. Those are the address-to-page mapping, combined programs being chosen exactly when both pages of a row are dirty, and the slow latency being chosen by real high-bit changes rather than by dirtiness. They also cover data surviving eviction and reload. The bench shows all of this by driving directed eviction sequences and a random tail against a behavioural model.

// File: rtl/mlc_pagebuf.sv
module mlc_pagebuf #(
  parameter int ROWS   = 4,
  parameter int BPP    = 4,
  parameter int X      = 2,
  parameter int DW     = 512,
  parameter int CW     = 16,
  parameter int T_FULL = 25,
  parameter int T_LSB  = 21,
  parameter int T_LOAD = 3,
  parameter int AW     = $clog2(ROWS) + $clog2(2*BPP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          busy,
  output logic          prog_start,
  output logic          prog_dual,
  output logic          prog_slow,
  output logic [CW-1:0] hit_lsb,
  output logic [CW-1:0] hit_msb,
  output logic [CW-1:0] miss_lsb,
  output logic [CW-1:0] miss_msb
);
  localparam int RBW = $clog2(2*BPP);
  localparam int BW  = $clog2(BPP);
  localparam int XW  = $clog2(X);
  localparam int RW  = $clog2(ROWS);
  localparam int TW  = $clog2(T_FULL + T_LOAD + 1);
  localparam int NA  = ROWS*2*BPP;

  typedef enum logic [1:0] {S_IDLE, S_PROG, S_LOAD} st_t;
  st_t st;
  logic [TW-1:0] cnt;
  logic [DW-1:0] arr [NA];
  logic [DW-1:0] pb  [2*BPP];
  logic [RW-1:0] tag [2];
  logic [1:0]    val, dirty;
  logic          missed;
  logic [CW-1:0] hits [2];
  logic [CW-1:0] misses [2];

  wire [RBW-1:0] blk  = req_addr[RBW-1:0];
  wire [RW-1:0]  row  = req_addr[AW-1:RBW];
  wire [RBW-1:0] grp  = blk >> XW;
  wire           pg   = grp[0];
  wire           op   = ~pg;
  wire [RBW-1:0] slw  = ((grp >> 1) << XW) | (blk & RBW'(X-1));
  wire [BW-1:0]  slot = slw[BW-1:0];
  wire           hit  = val[pg] && tag[pg] == row;
  wire           dual = val[op] && dirty[op] && tag[op] == tag[pg];

  function automatic int aidx(logic [RW-1:0] r, logic p, int s);
    return (int'(r)*2 + int'(p))*BPP + s;
  endfunction

  logic msb_diff;
  always_comb begin
    msb_diff = 1'b0;
    for (int i = 0; i < BPP; i++)
      if (pb[BPP+i] != arr[aidx(tag[1], 1'b1, i)]) msb_diff = 1'b1;
  end
  wire slow = (pg || dual) && msb_diff;

  assign req_ready = st == S_IDLE && req_valid && hit;
  assign busy      = st != S_IDLE;
  assign hit_lsb   = hits[0];
  assign hit_msb   = hits[1];
  assign miss_lsb  = misses[0];
  assign miss_msb  = misses[1];

  always_ff @(posedge clk) begin
    rsp_valid  <= 1'b0;
    prog_start <= 1'b0;
    prog_dual  <= 1'b0;
    prog_slow  <= 1'b0;
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; val <= '0; dirty <= '0; missed <= 1'b0;
      rsp_rdata <= '0;
      for (int p = 0; p < 2; p++) begin
        tag[p] <= '0; hits[p] <= '0; misses[p] <= '0;
      end
      for (int i = 0; i < NA; i++) arr[i] <= '0;
      for (int i = 0; i < 2*BPP; i++) pb[i] <= '0;
    end else if (st != S_IDLE) begin
      if (cnt == '0) st <= S_IDLE;
      else cnt <= cnt - 1'b1;
    end else if (req_valid) begin
      if (hit) begin
        if (req_write) begin
          pb[int'(pg)*BPP + int'(slot)] <= req_wdata;
          dirty[pg] <= 1'b1;
        end else begin
          rsp_rdata <= pb[int'(pg)*BPP + int'(slot)];
          rsp_valid <= 1'b1;
        end
        if (!missed) hits[pg] <= hits[pg] + 1'b1;
        missed <= 1'b0;
      end else if (val[pg] && dirty[pg]) begin
        for (int i = 0; i < BPP; i++) begin
          arr[aidx(tag[pg], pg, i)] <= pb[int'(pg)*BPP + i];
          if (dual) arr[aidx(tag[op], op, i)] <= pb[int'(op)*BPP + i];
        end
        dirty[pg] <= 1'b0;
        if (dual) dirty[op] <= 1'b0;
        cnt        <= TW'(slow ? T_FULL-1 : T_LSB-1);
        st         <= S_PROG;
        prog_start <= 1'b1;
        prog_dual  <= dual;
        prog_slow  <= slow;
      end else begin
        for (int i = 0; i < BPP; i++) pb[int'(pg)*BPP + i] <= arr[aidx(row, pg, i)];
        tag[pg]    <= row;
        val[pg]    <= 1'b1;
        dirty[pg]  <= 1'b0;
        misses[pg] <= misses[pg] + 1'b1;
        missed     <= 1'b1;
        cnt        <= TW'(T_LOAD-1);
        st         <= S_LOAD;
      end
    end
  end

  // R8
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !req_ready);
  // R3
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));
  // R9
  hit_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lsb != $past(hit_lsb) || hit_msb != $past(hit_msb)) |-> $past(req_ready));
  // R7
  prog_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> (st == S_PROG && cnt == (prog_slow ? TW'(T_FULL-1) : TW'(T_LSB-1))));
  // R6
  dual_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n) prog_dual |-> prog_start);
endmodule

// File: tb/tb_mlc_pagebuf.sv
module tb_mlc_pagebuf;
  localparam int CLK_P = 10;
  localparam int ROWS = 4, BPP = 4, X = 2, DW = 512, CW = 16;
  localparam int T_FULL = 25, T_LSB = 21, T_LOAD = 3;
  localparam int AW = 5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, busy, prog_start, prog_dual, prog_slow;
  logic [DW-1:0] rsp_rdata;
  logic [CW-1:0] hit_lsb, hit_msb, miss_lsb, miss_msb;

  always #(CLK_P/2) clk = ~clk;

  mlc_pagebuf #(.ROWS(ROWS), .BPP(BPP), .X(X), .DW(DW), .CW(CW), .T_FULL(T_FULL),
    .T_LSB(T_LSB), .T_LOAD(T_LOAD), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy), .prog_start(prog_start),
    .prog_dual(prog_dual), .prog_slow(prog_slow), .hit_lsb(hit_lsb), .hit_msb(hit_msb),
    .miss_lsb(miss_lsb), .miss_msb(miss_msb));

  int total = 0, bad = 0;

  task automatic ck(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model
  logic [DW-1:0] marr [ROWS*2*BPP];
  logic [DW-1:0] mbuf [2][BPP];
  int  mtag [2];
  bit  mval [2], mdirty [2];
  bit  mmissed;
  int  mstate, mcnt;
  int  mhit [2], mmiss [2];
  bit  e_rv, e_ps, e_pd, e_sl;
  logic [DW-1:0] e_rd;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS*2*BPP; i++) marr[i] = '0;
      for (int p = 0; p < 2; p++) begin
        mval[p] = 0; mdirty[p] = 0; mtag[p] = 0; mhit[p] = 0; mmiss[p] = 0;
        for (int s = 0; s < BPP; s++) mbuf[p][s] = '0;
      end
      mmissed = 0; mstate = 0; mcnt = 0;
      e_rv = 0; e_ps = 0; e_pd = 0; e_sl = 0; e_rd = '0;
    end else begin
      int b, r, g, p, o, s;
      bit h, dual, diff;
      b = int'(req_addr) % (2*BPP);
      r = int'(req_addr) / (2*BPP);
      g = b / X;
      p = g % 2;
      o = 1 - p;
      s = (g / 2) * X + b % X;
      h = mval[p] && mtag[p] == r;
      ck("R8 req_ready", req_ready, (mstate == 0 && req_valid && h));
      ck("R8 busy", busy, mstate != 0);
      ck("R3 rsp_valid", rsp_valid, e_rv);
      if (e_rv) ck("R3/R5 rsp_rdata", rsp_rdata, e_rd);
      ck("R4/R5 prog_start", prog_start, e_ps);
      ck("R6 prog_dual", prog_dual, e_pd);
      ck("R7 prog_slow", prog_slow, e_sl);
      ck("R1/R9 hit_lsb", hit_lsb, mhit[0]);
      ck("R1/R9 hit_msb", hit_msb, mhit[1]);
      ck("R1/R9 miss_lsb", miss_lsb, mmiss[0]);
      ck("R1/R9 miss_msb", miss_msb, mmiss[1]);
      e_rv = 0; e_ps = 0; e_pd = 0; e_sl = 0;
      if (mstate != 0) begin
        if (mcnt == 0) mstate = 0; else mcnt--;
      end else if (req_valid) begin
        if (h) begin
          if (req_write) begin mbuf[p][s] = req_wdata; mdirty[p] = 1; end
          else begin e_rd = mbuf[p][s]; e_rv = 1; end
          if (!mmissed) mhit[p]++;
          mmissed = 0;
        end else if (mval[p] && mdirty[p]) begin
          dual = mval[o] && mdirty[o] && mtag[o] == mtag[p];
          diff = 0;
          for (int i = 0; i < BPP; i++)
            if (mbuf[1][i] != marr[(mtag[1]*2+1)*BPP+i]) diff = 1;
          e_sl = (p == 1 || dual) && diff;
          for (int i = 0; i < BPP; i++) begin
            marr[(mtag[p]*2+p)*BPP+i] = mbuf[p][i];
            if (dual) marr[(mtag[o]*2+o)*BPP+i] = mbuf[o][i];
          end
          mdirty[p] = 0;
          if (dual) mdirty[o] = 0;
          e_ps = 1; e_pd = dual;
          mcnt = (e_sl ? T_FULL : T_LSB) - 1;
          mstate = 1;
        end else begin
          for (int i = 0; i < BPP; i++) mbuf[p][i] = marr[(r*2+p)*BPP+i];
          mtag[p] = r; mval[p] = 1; mdirty[p] = 0;
          mmiss[p]++; mmissed = 1;
          mcnt = T_LOAD - 1; mstate = 2;
        end
      end
    end
  end

  task automatic rq(bit w, int a, logic [DW-1:0] d);
    bit acc;
    @(posedge clk); #1;
    req_valid = 1; req_write = w; req_addr = AW'(a); req_wdata = d;
    forever begin
      @(negedge clk); acc = req_ready;
      @(posedge clk);
      if (acc) break;
    end
    #1 req_valid = 0;
  endtask

  // counts prog pulses during a request to check one-shot combined program
  int nprog, ndual, nslow;
  always @(negedge clk) if (rst_n) begin
    nprog += int'(prog_start); ndual += int'(prog_dual); nslow += int'(prog_slow);
  end

  localparam logic [DW-1:0] DA = {16{32'hA5A5_0001}};
  localparam logic [DW-1:0] DB = {16{32'h0BB0_0002}};

  initial begin
    nprog = 0; ndual = 0; nslow = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10 reset state
    ck("R10 busy", busy, 0);
    ck("R10 counters", {hit_lsb, hit_msb, miss_lsb, miss_msb}, '0);
    rq(0, 0, '0);                 // R4 clean miss low page, row 0
    rq(1, 0, DA);                 // R3 write hit
    rq(0, 2, '0);                 // R2 high page row 0 loads independently
    rq(1, 3, DB);                 // high dirty
    nprog = 0; ndual = 0; nslow = 0;
    rq(0, 8, '0);                 // R6 both dirty same row -> one combined program, slow
    @(negedge clk);
    ck("R6 one program", nprog, 1);
    ck("R6 combined", ndual, 1);
    ck("R7 slow when high bits change", nslow, 1);
    rq(0, 0, '0);                 // R5 reload row 0 low, data DA
    @(negedge clk);
    ck("R5 data after writeback", rsp_rdata, DA);
    rq(0, 3, '0);
    @(negedge clk);
    ck("R5 high data after writeback", rsp_rdata, DB);
    rq(1, 1, DB);
    nprog = 0; nslow = 0;
    rq(0, 16, '0);                // low-only program: fast
    @(negedge clk);
    ck("R7 low-only program fast", nslow, 0);
    ck("R5 low-only program issued", nprog, 1);
    rq(1, 26, '0);                // high dirty but unchanged
    nprog = 0; nslow = 0; ndual = 0;
    rq(0, 2, '0);
    @(negedge clk);
    ck("R7 unchanged high bits fast", nslow, 0);
    ck("R6 no combine across rows", ndual, 0);
    for (int k = 0; k < 80; k++)
      rq(bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)), {16{$urandom()}});
    repeat (40) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule